// File: doc/BRIEF.md
# Unaligned Byte Pattern Generator

This block fills a 16 KB circular transmit buffer with a test byte stream of programmable length. Software picks one of four patterns and a byte count, then pulses a start strobe. The block then sends 128-bit beats, each with 16 byte enables, to the buffer writer. The stream begins at the block's own write pointer. That pointer may sit at any byte address, so the first beat and the last beat can be partial.

Each accepted beat moves the write pointer forward by the bytes it carried. The block compares its write pointer with the consumer's read pointer and never offers a beat that would overwrite unread data. While it runs it reports busy and the number of bytes still to send. While it is busy it also tells the host that the buffer is closed to host writes.

The beat output is a valid/ready stream. The block raises `out_valid` only when the whole next beat fits in the free space. Once `out_valid` is high, the block holds it and holds `out_beat`, `out_data` and `out_be` unchanged until `out_ready` is sampled high at a clock edge. A beat is transferred on every edge where both `out_valid` and `out_ready` are high. The consumer may keep `out_ready` low for as long as it needs.

Top module: `txpat_gen`

## Requirements
- R1: After reset, `busy` and `out_valid` are 0, `wr_ptr` and `remain` are 0, and `host_buf_open` is 1.
- R2: Stream byte j (counting from 0) has a value set by `mode`:
  - 2'b00 gives 8'hFF minus (j mod 256).
  - 2'b01 gives j mod 256.
  - 2'b10 gives 8'h39 minus (j mod 10), the ASCII digits '9' down to '0'.
  - 2'b11 gives 8'h30 plus (j mod 10), the ASCII digits '0' up to '9'.
- R3: The stream byte written at buffer address A is carried in lane A[3:0], that is, in bits [8*A[3:0]+7 : 8*A[3:0]] of `out_data`. Its `out_be` bit is A[3:0], and `out_beat` equals A[13:4]. The first beat enables lanes starting from the start offset `wr_ptr[3:0]`.
- R4: Each beat enables a contiguous run of lanes. The run covers min(16 − offset, remaining) bytes, so the final beat stops at the last byte. Lanes whose enable is 0 carry data 8'h00.
- R5: After each accepted beat, `wr_ptr` grows by the number of enabled lanes, modulo 16384. After the last beat, `wr_ptr` equals the start address plus the length, modulo 16384.
- R6: `out_valid` stays 0 while the free space, (`rd_ptr` − `wr_ptr` − 1) mod 16384, is smaller than the byte count of the next beat.
- R7: While `out_valid` is 1 and `out_ready` is 0, the beat address, data and enables hold steady and `wr_ptr` does not move.
- R8: `busy` is 1 in the cycle after an accepted start. It returns to 0 in the cycle after the final beat is accepted. While busy, `remain` equals the length minus the bytes already accepted.
- R9: A start is ignored if it arrives while busy or with a length of 0. A pointer load (`ptr_load`) is ignored while busy.
- R10: `host_buf_open` is 0 exactly while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe; captures `mode` and `length` |
| mode | input | 2 | Pattern select |
| length | input | 32 | Byte count of the stream |
| ptr_load | input | 1 | Load `wr_ptr` from `ptr_load_val` while idle |
| ptr_load_val | input | 14 | New write pointer (start byte address) |
| rd_ptr | input | 14 | Consumer read pointer |
| wr_ptr | output | 14 | Write pointer: one past the last byte written |
| busy | output | 1 | Generation in progress |
| remain | output | 32 | Bytes not yet accepted |
| host_buf_open | output | 1 | Host may write the buffer |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_beat | output | 10 | Beat address in the buffer (byte address bits 13:4) |
| out_data | output | 128 | Beat data, lane n in bits 8n+7:8n |
| out_be | output | 16 | Byte enables, one per lane |

## Verification
Flow control and back-pressure are hard to exercise together from the ports. To reach that state the bench loads the write pointer to a known start, parks `rd_ptr` only a few bytes ahead of it, and then starts a stream longer than that free space. The block must then sit busy with no valid beat, and it must ignore both a second start and a pointer load. The bench then opens space with `out_ready` held low, which makes the offered beat stay frozen before it is released. A table of unaligned starts separately covers single-beat streams, streams that end exactly at a lane boundary, and streams that cross the end of the ring.

// File: rtl/txpat_pkg.sv
package txpat_pkg;

  typedef enum logic [1:0] {
    PM_BIN_DN = 2'b00,
    PM_BIN_UP = 2'b01,
    PM_TXT_DN = 2'b10,
    PM_TXT_UP = 2'b11
  } pat_mode_e;

  localparam logic [7:0] CHR_ZERO = 8'h30;
  localparam logic [7:0] CHR_NINE = 8'h39;
  localparam logic [7:0] BIN_TOP  = 8'hFF;

endpackage

// File: rtl/txpat_planner.sv
module txpat_planner #(
  parameter int LANES = 16,
  parameter int LEN_W = 32,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [LANE_W-1:0] offset,
  input  logic [LEN_W-1:0]  remain,
  output logic [LANE_W:0]   nbytes,
  output logic [LANES-1:0]  be
);

  logic [LANE_W:0] room;
  logic [LANE_W:0] stop;

  always_comb begin
    room = (LANE_W+1)'(LANES) - {1'b0, offset};
    if (remain < LEN_W'(room)) nbytes = remain[LANE_W:0];
    else                       nbytes = room;
    stop = {1'b0, offset} + nbytes;
  end

  for (genvar gl = 0; gl < LANES; gl++) begin : g_be
    assign be[gl] = ({1'b0, offset} <= (LANE_W+1)'(gl)) && ((LANE_W+1)'(gl) < stop);
  end

endmodule

// File: rtl/txpat_lane.sv
module txpat_lane
  import txpat_pkg::*;
#(
  parameter int LANE  = 0,
  parameter int LANES = 16,
  localparam int LANE_W = $clog2(LANES)
) (
  input  pat_mode_e         mode,
  input  logic              en,
  input  logic [LANE_W-1:0] offset,
  input  logic [7:0]        bin_cnt,
  input  logic [3:0]        txt_idx,
  output logic [7:0]        byte_o
);

  logic [LANE_W:0] k;
  logic [7:0]      binv;
  logic [LANE_W+2:0] s;
  logic [3:0]      digit;
  logic [7:0]      val;

  always_comb begin
    k    = (LANE_W+1)'(LANE) - {1'b0, offset};
    binv = bin_cnt + 8'(k);
    s    = (LANE_W+3)'(txt_idx) + (LANE_W+3)'(k);
    if (s >= (LANE_W+3)'(20))      s = s - (LANE_W+3)'(20);
    else if (s >= (LANE_W+3)'(10)) s = s - (LANE_W+3)'(10);
    digit = s[3:0];
    unique case (mode)
      PM_BIN_DN: val = BIN_TOP - binv;
      PM_BIN_UP: val = binv;
      PM_TXT_DN: val = CHR_NINE - 8'(digit);
      default:   val = CHR_ZERO + 8'(digit);
    endcase
    byte_o = en ? val : 8'h00;
  end

endmodule

// File: rtl/txpat_flow.sv
module txpat_flow #(
  parameter int ADDR_W = 14,
  parameter int CNT_W  = 5
) (
  input  logic [ADDR_W-1:0] rd_ptr,
  input  logic [ADDR_W-1:0] wr_ptr,
  input  logic [CNT_W-1:0]  need,
  output logic              room_ok
);

  logic [ADDR_W-1:0] free_bytes;

  always_comb begin
    free_bytes = rd_ptr + ~wr_ptr;
    room_ok    = free_bytes >= ADDR_W'(need);
  end

endmodule

// File: rtl/txpat_gen.sv
module txpat_gen
  import txpat_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int LANES  = 16,
  parameter int LEN_W  = 32,
  localparam int LANE_W = $clog2(LANES),
  localparam int BEAT_W = ADDR_W - LANE_W,
  localparam int DATA_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [LEN_W-1:0]  length,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_load_val,
  input  logic [ADDR_W-1:0] rd_ptr,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic              busy,
  output logic [LEN_W-1:0]  remain,
  output logic              host_buf_open,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BEAT_W-1:0] out_beat,
  output logic [DATA_W-1:0] out_data,
  output logic [LANES-1:0]  out_be
);

  logic [ADDR_W-1:0] wr_q;
  logic              busy_q;
  logic [LEN_W-1:0]  remain_q;
  pat_mode_e         mode_q;
  logic [7:0]        bin_q;
  logic [3:0]        txt_q;

  logic [LANE_W-1:0] offset;
  logic [LANE_W:0]   nbytes;
  logic [LANES-1:0]  be;
  logic              room_ok;
  logic              accept;
  logic              take_start;
  logic [LANE_W+2:0] txt_sum;
  logic [3:0]        txt_next;

  assign offset = wr_q[LANE_W-1:0];

  txpat_planner #(.LANES(LANES), .LEN_W(LEN_W)) u_plan (
    .offset (offset),
    .remain (remain_q),
    .nbytes (nbytes),
    .be     (be)
  );

  txpat_flow #(.ADDR_W(ADDR_W), .CNT_W(LANE_W+1)) u_flow (
    .rd_ptr  (rd_ptr),
    .wr_ptr  (wr_q),
    .need    (nbytes),
    .room_ok (room_ok)
  );

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    txpat_lane #(.LANE(gl), .LANES(LANES)) u_lane (
      .mode    (mode_q),
      .en      (be[gl]),
      .offset  (offset),
      .bin_cnt (bin_q),
      .txt_idx (txt_q),
      .byte_o  (out_data[8*gl +: 8])
    );
  end

  assign out_valid     = busy_q && room_ok;
  assign out_be        = out_valid ? be : '0;
  assign out_beat      = wr_q[ADDR_W-1:LANE_W];
  assign accept        = out_valid && out_ready;
  assign take_start    = start && !busy_q && (length != '0);
  assign wr_ptr        = wr_q;
  assign busy          = busy_q;
  assign remain        = remain_q;
  assign host_buf_open = !busy_q;

  always_comb begin
    txt_sum = (LANE_W+3)'(txt_q) + (LANE_W+3)'(nbytes);
    if (txt_sum >= (LANE_W+3)'(20))      txt_sum = txt_sum - (LANE_W+3)'(20);
    else if (txt_sum >= (LANE_W+3)'(10)) txt_sum = txt_sum - (LANE_W+3)'(10);
    txt_next = txt_sum[3:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q     <= '0;
      busy_q   <= 1'b0;
      remain_q <= '0;
      mode_q   <= PM_BIN_DN;
      bin_q    <= '0;
      txt_q    <= '0;
    end else begin
      if (ptr_load && !busy_q) wr_q <= ptr_load_val;
      if (take_start) begin
        busy_q   <= 1'b1;
        remain_q <= length;
        mode_q   <= pat_mode_e'(mode);
        bin_q    <= '0;
        txt_q    <= '0;
      end else if (accept) begin
        wr_q     <= wr_q + ADDR_W'(nbytes);
        remain_q <= remain_q - LEN_W'(nbytes);
        bin_q    <= bin_q + 8'(nbytes);
        txt_q    <= txt_next;
        if (remain_q == LEN_W'(nbytes)) busy_q <= 1'b0;
      end
    end
  end

  // R7: an offered beat is frozen until taken
  a_r7_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_be)
                                   && $stable(out_beat) && $stable(wr_ptr)));

  // R6: never offer more bytes than the ring can take
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ADDR_W'($countones(out_be)) <= ADDR_W'(rd_ptr - wr_ptr - ADDR_W'(1))));

  // R5: pointer steps by the enabled byte count
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (wr_ptr == $past(wr_ptr) + ADDR_W'($countones($past(out_be)))));

  // R8: no beats while idle, and a busy block always has bytes to send
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);
  a_r8_busy_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (remain != '0));

  // R4: every offered beat carries at least one byte
  a_r4_beat_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_be != '0));

endmodule

// File: tb/txpat_gen_bench.sv
module txpat_gen_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [31:0]  length = '0;
  logic         ptr_load = 1'b0;
  logic [13:0]  ptr_load_val = '0;
  logic [13:0]  rd_ptr = '0;
  logic [13:0]  wr_ptr;
  logic         busy;
  logic [31:0]  remain;
  logic         host_buf_open;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [9:0]   out_beat;
  logic [127:0] out_data;
  logic [15:0]  out_be;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  txpat_gen u_txpat_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .length(length),
    .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .rd_ptr(rd_ptr),
    .wr_ptr(wr_ptr), .busy(busy), .remain(remain), .host_buf_open(host_buf_open),
    .out_valid(out_valid), .out_ready(out_ready), .out_beat(out_beat),
    .out_data(out_data), .out_be(out_be)
  );

  // {start pointer, mode, length}
  localparam int NVEC = 8;
  localparam logic [47:0] VEC [NVEC] = '{
    {14'd0,     2'b01, 32'd16},
    {14'd0,     2'b00, 32'd40},
    {14'd5,     2'b11, 32'd7},
    {14'd3,     2'b10, 32'd13},
    {14'h1F,    2'b11, 32'd451},
    {14'd16380, 2'b01, 32'd40},
    {14'd9,     2'b00, 32'd300},
    {14'd15,    2'b10, 32'd1}
  };

  function automatic logic [7:0] exp_byte(input logic [1:0] m, input int unsigned j);
    case (m)
      2'b00:   return 8'hFF - 8'(j % 256);
      2'b01:   return 8'(j % 256);
      2'b10:   return 8'h39 - 8'(j % 10);
      default: return 8'h30 + 8'(j % 10);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #3;
  endtask

  task automatic run_vec(input logic [13:0] p, input logic [1:0] m, input int unsigned len);
    int unsigned j = 0;
    int guard = 0;
    logic [13:0] a;
    int unsigned off, n;
    logic [15:0] ebe;
    logic [127:0] edat;
    out_ready = 1'b1;
    ptr_load = 1'b1; ptr_load_val = p;
    step();
    ptr_load = 1'b0; rd_ptr = p;
    #1 chk(wr_ptr == p, "R5 load", 128'(wr_ptr), 128'(p));
    start = 1'b1; mode = m; length = len;
    step();
    start = 1'b0;
    #1 chk(busy == 1'b1, "R8 busy rise", 128'(busy), 128'd1);
    while (j < len && guard < 2000) begin
      if (out_valid) begin
        a = p + 14'(j);
        off = 32'(a[3:0]);
        n = (16 - off < len - j) ? 16 - off : len - j;
        ebe = '0; edat = '0;
        for (int l = 0; l < 16; l++)
          if (l >= int'(off) && l < int'(off + n)) begin
            ebe[l] = 1'b1;
            edat[8*l +: 8] = exp_byte(m, j + 32'(l) - off);
          end
        chk(out_beat == a[13:4], "R3 beat address", 128'(out_beat), 128'(a[13:4]));
        chk(out_be == ebe, "R4 byte enables", 128'(out_be), 128'(ebe));
        chk(out_data == edat, "R2 lane data", out_data, edat);
        chk(remain == len - j, "R8 remain", 128'(remain), 128'(len - j));
        j += n;
      end
      step();
      #1;
      guard++;
    end
    chk(busy == 1'b0, "R8 busy clear", 128'(busy), 128'd0);
    chk(wr_ptr == 14'(p + 14'(len)), "R5 final pointer", 128'(wr_ptr), 128'(14'(p + 14'(len))));
    chk(remain == 0, "R8 remain zero", 128'(remain), 128'd0);
  endtask

  initial begin
    logic [127:0] held_d;
    logic [15:0]  held_be;
    int guard;
    // R1 reset state
    step(); step();
    #1;
    chk(busy == 1'b0 && out_valid == 1'b0, "R1 reset busy/valid", 128'({busy, out_valid}), 128'd0);
    chk(wr_ptr == '0 && remain == '0, "R1 reset pointer/remain", 128'({wr_ptr, remain}), 128'd0);
    chk(host_buf_open == 1'b1, "R1 reset host open", 128'(host_buf_open), 128'd1);
    rst_n = 1'b1;
    step();

    for (int v = 0; v < NVEC; v++)
      run_vec(VEC[v][47:34], VEC[v][33:32], VEC[v][31:0]);

    // R9: zero length start is ignored
    start = 1'b1; mode = 2'b01; length = 0;
    step();
    start = 1'b0;
    #1 chk(busy == 1'b0, "R9 zero length", 128'(busy), 128'd0);

    // R6 stall: four free bytes, a 16-byte beat pending
    ptr_load = 1'b1; ptr_load_val = 14'd32;
    step();
    ptr_load = 1'b0; rd_ptr = 14'd37;
    start = 1'b1; mode = 2'b01; length = 20;
    step();
    start = 1'b0;
    #1;
    chk(busy == 1'b1 && out_valid == 1'b0, "R6 stall", 128'({busy, out_valid}), 128'b10);
    chk(host_buf_open == 1'b0, "R10 closed while busy", 128'(host_buf_open), 128'd0);
    start = 1'b1; length = 99;
    ptr_load = 1'b1; ptr_load_val = 14'd100;
    step();
    start = 1'b0; ptr_load = 1'b0;
    #1;
    chk(remain == 20, "R9 start while busy", 128'(remain), 128'd20);
    chk(wr_ptr == 14'd32, "R9 load while busy", 128'(wr_ptr), 128'd32);
    chk(out_valid == 1'b0, "R6 still stalled", 128'(out_valid), 128'd0);

    // R7: open space with ready low
    out_ready = 1'b0; rd_ptr = 14'd72;
    #1;
    chk(out_valid == 1'b1 && out_be == 16'hFFFF, "R6 released", 128'({out_valid, out_be}), 128'h1FFFF);
    held_d = out_data; held_be = out_be;
    step(); step();
    #1;
    chk(out_valid && out_data == held_d && out_be == held_be, "R7 held data", out_data, held_d);
    chk(wr_ptr == 14'd32, "R7 pointer held", 128'(wr_ptr), 128'd32);
    out_ready = 1'b1;
    guard = 0;
    while (busy && guard < 100) begin step(); guard++; end
    #1;
    chk(wr_ptr == 14'd52, "R5 after stall", 128'(wr_ptr), 128'd52);
    chk(host_buf_open == 1'b1, "R10 open when idle", 128'(host_buf_open), 128'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule